// File: doc/BRIEF.md
# Converter Offset Calibration and Compensation Engine

This block learns the residual offset of a current-sense voltage-to-frequency converter and then cancels it inside the charge bookkeeping. A calibration can be started in two ways: a host request bit or a calibrate command. Once started, the engine waits until the sense signal is reported quiet. It then measures how many timebase ticks separate two converter pulses of the same polarity. The result is kept as a 20-bit period together with a polarity flag.

Compensation can be enabled after a calibration has completed. When it is enabled, the engine emits one synthetic increment strobe every stored period. The strobe goes to the counter opposite the offset polarity, so it cancels the drift that the offset would otherwise add. There are two ways a measurement can fail to finish normally. A pulse of the wrong polarity makes the engine throw the measurement away and start again. A measurement that drags on too long ends with a default offset. The surrounding charge counters, the quiet comparator and the timebase divider live outside this block.

Top module: `ocal_engine`

## Requirements
- R1: After reset, `cal_req` is 0, `cal_stat` is 1, `comp_en` is 0, `offset_period` is 0, `offset_pos` is 0, and neither increment strobe is high.
- R2: A one-cycle pulse on `cal_req_set` or on `cal_cmd` sets `cal_req` to 1 and `cal_stat` to 1 at the next clock edge. It also starts a calibration, and restarts one that is already running.
- R3: After a start, measurement begins only once `quiet` is 1. Converter pulses and ticks seen before that have no effect on the result.
- R4: The stored period is the number of ticks after the first counted pulse, up to and including the cycle of the next pulse of the same polarity. A tick that coincides with the first pulse is not counted. A tick that coincides with the second pulse is counted. `offset_pos` becomes 1 when the pulses were on `vfc_pos` and 0 when they were on `vfc_neg`.
- R5: If the second pulse has the opposite polarity, the measurement is discarded and calibration continues. The next pulse after that becomes the new first pulse.
- R6: A cycle with both `vfc_pos` and `vfc_neg` high is treated as no pulse.
- R7: The engine may wait for the first pulse, or for the second, for 2^TO_BIT ticks. At the next clock edge after that, calibration ends with `offset_period` = DEFAULT_PERIOD and `offset_pos` = DEFAULT_POS.
- R8: When a calibration ends (by measurement or by timeout), `cal_req` and `cal_stat` both fall to 0 at the same edge that loads the result.
- R9: The compensation enable is written through `en_wr`/`en_wdata`, resets to 0, and is visible on `comp_en` after the next edge.
- R10: While `comp_en` = 1, `cal_stat` = 0 and the period is nonzero, exactly one strobe is emitted per `offset_period` ticks. The strobe is visible in the cycle after the clock edge that takes the completing tick. It appears on `inc_dis` when `offset_pos` = 1 and on `inc_chg` when it is 0, and never on both.
- R11: No strobe is produced while `comp_en` = 0, while `cal_stat` = 1 (a calibration is in progress), or while `offset_period` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase tick (9.76 ms period in the system) |
| vfc_pos | input | 1 | One-cycle converter pulse, positive polarity |
| vfc_neg | input | 1 | One-cycle converter pulse, negative polarity |
| quiet | input | 1 | Sense signal magnitude is below the wake threshold |
| cal_req_set | input | 1 | Host writes the calibration request bit to 1 |
| cal_cmd | input | 1 | Calibrate command strobe |
| en_wr | input | 1 | Write strobe for the compensation enable |
| en_wdata | input | 1 | Value written to the compensation enable |
| cal_req | output | 1 | Calibration request pending |
| cal_stat | output | 1 | 1 = no fresh result; 0 = calibration completed |
| comp_en | output | 1 | Compensation enable readback |
| offset_period | output | 20 | Stored offset period in ticks |
| offset_pos | output | 1 | Offset polarity (1 = positive) |
| inc_chg | output | 1 | Synthetic increment for the charge counter |
| inc_dis | output | 1 | Synthetic increment for the discharge counter |

## Verification
Two functions can fall into a single cycle: the closing converter pulse and a timebase tick. The tick must be folded into the stored period, or the result comes out one short. The bench provokes this by driving the second same-polarity pulse together with a tick, and expects a period one larger than the ticks seen strictly between the pulses. A second overlap happens when a new request arrives while compensation is running. Compensation must stop at that edge, and the bench judges this by counting strobes over many ticks while a calibration is held waiting for the quiet condition.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,
    CS_QUIET  = 2'd1,
    CS_FIRST  = 2'd2,
    CS_SECOND = 2'd3
  } cal_state_e;
endpackage

// File: rtl/ocal_meas.sv
module ocal_meas
  import ocal_pkg::*;
#(
  parameter int unsigned CNT_W          = 20,
  parameter int unsigned TO_BIT         = 17,
  parameter logic [CNT_W-1:0] DEFAULT_PERIOD = 20'd262200,
  parameter logic        DEFAULT_POS    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             vfc_pos_i,
  input  logic             vfc_neg_i,
  input  logic             quiet_i,
  input  logic             start_i,
  output logic             req_o,
  output logic             stat_o,
  output logic [CNT_W-1:0] period_o,
  output logic             pos_o
);
  localparam logic [CNT_W-1:0] TO_LIMIT = CNT_W'(1) << TO_BIT;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  cal_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic             pos_q, pos_d;
  logic             first_pos_q, first_pos_d;
  logic             req_q, req_d;
  logic             stat_q, stat_d;

  logic             pulse_any, pulse_is_pos, timed_out;
  logic [CNT_W-1:0] cnt_tick, cnt_close;

  assign pulse_any    = vfc_pos_i ^ vfc_neg_i;
  assign pulse_is_pos = vfc_pos_i & ~vfc_neg_i;
  assign timed_out    = cnt_q[TO_BIT];
  assign cnt_tick     = cnt_q + ONE;
  assign cnt_close    = tick_i ? cnt_tick : cnt_q;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    period_d    = period_q;
    pos_d       = pos_q;
    first_pos_d = first_pos_q;
    req_d       = req_q;
    stat_d      = stat_q;
    if (start_i) begin
      state_d = CS_QUIET;
      cnt_d   = '0;
      req_d   = 1'b1;
      stat_d  = 1'b1;
    end else begin
      unique case (state_q)
        CS_IDLE: ;
        CS_QUIET: begin
          if (quiet_i) begin
            state_d = CS_FIRST;
            cnt_d   = '0;
          end
        end
        CS_FIRST: begin
          if (timed_out) begin
            state_d  = CS_IDLE;
            period_d = DEFAULT_PERIOD;
            pos_d    = DEFAULT_POS;
            req_d    = 1'b0;
            stat_d   = 1'b0;
          end else if (pulse_any) begin
            state_d     = CS_SECOND;
            first_pos_d = pulse_is_pos;
            cnt_d       = '0;
          end else if (tick_i) begin
            cnt_d = cnt_tick;
          end
        end
        CS_SECOND: begin
          if (timed_out) begin
            state_d  = CS_IDLE;
            period_d = DEFAULT_PERIOD;
            pos_d    = DEFAULT_POS;
            req_d    = 1'b0;
            stat_d   = 1'b0;
          end else if (pulse_any) begin
            if (pulse_is_pos == first_pos_q) begin
              state_d  = CS_IDLE;
              period_d = cnt_close;
              pos_d    = first_pos_q;
              req_d    = 1'b0;
              stat_d   = 1'b0;
            end else begin
              state_d = CS_FIRST;
              cnt_d   = '0;
            end
          end else if (tick_i) begin
            cnt_d = cnt_tick;
          end
        end
        default: state_d = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CS_IDLE;
      cnt_q       <= '0;
      period_q    <= '0;
      pos_q       <= 1'b0;
      first_pos_q <= 1'b0;
      req_q       <= 1'b0;
      stat_q      <= 1'b1;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      first_pos_q <= first_pos_d;
      req_q       <= req_d;
      stat_q      <= stat_d;
      if (state_q != CS_IDLE) begin
        period_q <= period_d;
        pos_q    <= pos_d;
      end
    end
  end

  assign req_o    = req_q;
  assign stat_o   = stat_q;
  assign period_o = period_q;
  assign pos_o    = pos_q;

  // R3: no progress out of the quiet wait while quiet is low
  a_r3_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_QUIET && !quiet_i && !start_i) |=> (state_q == CS_QUIET));

  // R4: stored result is frozen while idle
  a_r4_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_IDLE && !start_i) |=> ($stable(period_o) && $stable(pos_o)));

  // R7: the interval counter never passes the timeout limit
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TO_LIMIT);
endmodule

// File: rtl/ocal_comp.sv
module ocal_comp #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             pos_i,
  output logic             inc_chg_o,
  output logic             inc_dis_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] acc_q, acc_d;
  logic             run, fire;
  logic             chg_q, dis_q;

  assign run = active_i && (period_i != '0);

  always_comb begin
    acc_d = acc_q;
    fire  = 1'b0;
    if (!run) begin
      acc_d = '0;
    end else if (tick_i) begin
      if (acc_q == period_i - ONE) begin
        acc_d = '0;
        fire  = 1'b1;
      end else begin
        acc_d = acc_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      chg_q <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      chg_q <= fire & ~pos_i;
      dis_q <= fire & pos_i;
    end
  end

  assign inc_chg_o = chg_q;
  assign inc_dis_o = dis_q;

  // R10: the two strobes are never raised together
  a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_chg_o && inc_dis_o));

  // R10: a discharge strobe follows a positive offset
  a_r10_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    inc_dis_o |-> $past(pos_i));

  // R11: a strobe only follows a cycle with a nonzero period
  a_r11_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_chg_o || inc_dis_o) |-> ($past(period_i) != '0));
endmodule

// File: rtl/ocal_engine.sv
module ocal_engine #(
  parameter int unsigned CNT_W          = 20,
  parameter int unsigned TO_BIT         = 17,
  parameter logic [CNT_W-1:0] DEFAULT_PERIOD = 20'd262200,
  parameter logic        DEFAULT_POS    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             vfc_pos,
  input  logic             vfc_neg,
  input  logic             quiet,
  input  logic             cal_req_set,
  input  logic             cal_cmd,
  input  logic             en_wr,
  input  logic             en_wdata,
  output logic             cal_req,
  output logic             cal_stat,
  output logic             comp_en,
  output logic [CNT_W-1:0] offset_period,
  output logic             offset_pos,
  output logic             inc_chg,
  output logic             inc_dis
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       en_q, en_d;
  logic       start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign start = cal_req_set | cal_cmd;

  always_comb begin
    en_d = en_q;
    if (en_wr) en_d = en_wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) en_q <= 1'b0;
    else            en_q <= en_d;
  end
  assign comp_en = en_q;

  ocal_meas #(
    .CNT_W(CNT_W), .TO_BIT(TO_BIT),
    .DEFAULT_PERIOD(DEFAULT_PERIOD), .DEFAULT_POS(DEFAULT_POS)
  ) u_meas (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick),
    .vfc_pos_i(vfc_pos), .vfc_neg_i(vfc_neg), .quiet_i(quiet),
    .start_i(start), .req_o(cal_req), .stat_o(cal_stat),
    .period_o(offset_period), .pos_o(offset_pos)
  );

  ocal_comp #(.CNT_W(CNT_W)) u_comp (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick),
    .active_i(en_q & ~cal_stat), .period_i(offset_period),
    .pos_i(offset_pos), .inc_chg_o(inc_chg), .inc_dis_o(inc_dis)
  );

  // R2: an accepted start raises request and status
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_int_n)
    start |=> (cal_req && cal_stat));

  // R8: request falls only together with a fresh status
  a_r8_done: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(cal_req) |-> !cal_stat);

  // R11: strobes only after a cycle with compensation armed
  a_r11_gate: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inc_chg || inc_dis) |-> $past(comp_en && !cal_stat));
endmodule

// File: tb/tb_ocal_engine.sv
module tb_ocal_engine;
  localparam int W = 20;
  localparam logic [W-1:0] DEFP = 20'd9;

  logic clk = 1'b0;
  logic rst_n, tick, vfc_pos, vfc_neg, quiet, cal_req_set, cal_cmd, en_wr, en_wdata;
  logic cal_req, cal_stat, comp_en, offset_pos, inc_chg, inc_dis;
  logic [W-1:0] offset_period;

  int n_chk = 0;
  int n_bad = 0;
  int cnt_c, cnt_d;

  always #4 clk = ~clk;

  ocal_engine #(.CNT_W(W), .TO_BIT(6), .DEFAULT_PERIOD(DEFP), .DEFAULT_POS(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vfc_pos(vfc_pos), .vfc_neg(vfc_neg),
    .quiet(quiet), .cal_req_set(cal_req_set), .cal_cmd(cal_cmd), .en_wr(en_wr),
    .en_wdata(en_wdata), .cal_req(cal_req), .cal_stat(cal_stat), .comp_en(comp_en),
    .offset_period(offset_period), .offset_pos(offset_pos),
    .inc_chg(inc_chg), .inc_dis(inc_dis)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle, then return inputs to idle; outputs then show that edge
  task automatic step(input logic p, input logic n, input logic t);
    vfc_pos = p; vfc_neg = n; tick = t;
    @(negedge clk);
    vfc_pos = 0; vfc_neg = 0; tick = 0;
    cnt_c += int'(inc_chg);
    cnt_d += int'(inc_dis);
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 1);
  endtask

  task automatic start_cal(input logic use_cmd);
    if (use_cmd) cal_cmd = 1; else cal_req_set = 1;
    @(negedge clk);
    cal_cmd = 0; cal_req_set = 0;
  endtask

  task automatic write_en(input logic v);
    en_wr = 1; en_wdata = v;
    @(negedge clk);
    en_wr = 0;
  endtask

  task automatic t_reset;
    chk("R1 cal_req", cal_req, 0);
    chk("R1 cal_stat", cal_stat, 1);
    chk("R1 comp_en", comp_en, 0);
    chk("R1 period", offset_period, 0);
    chk("R1 pos", offset_pos, 0);
    chk("R1 strobes", {inc_chg, inc_dis}, 0);
  endtask

  // request bit start, positive offset, closing pulse shares a tick
  task automatic t_measure_pos;
    quiet = 1;
    start_cal(0);
    chk("R2 req after set", cal_req, 1);
    chk("R2 stat after set", cal_stat, 1);
    step(0, 0, 0);
    step(1, 0, 1);
    ticks(5);
    step(1, 0, 1);
    chk("R4 period pos", offset_period, 6);
    chk("R4 polarity pos", offset_pos, 1);
    chk("R8 req cleared", cal_req, 0);
    chk("R8 stat cleared", cal_stat, 0);
  endtask

  task automatic t_comp_pos;
    write_en(1);
    chk("R9 enable readback", comp_en, 1);
    cnt_c = 0; cnt_d = 0;
    ticks(18);
    step(0, 0, 0); step(0, 0, 0);
    chk("R10 dis strobes", cnt_d, 3);
    chk("R10 chg strobes", cnt_c, 0);
  endtask

  task automatic t_measure_neg_cmd;
    start_cal(1);
    chk("R2 req after cmd", cal_req, 1);
    step(0, 0, 0);
    step(0, 1, 1);
    ticks(3);
    step(0, 0, 0); step(0, 0, 0);
    step(0, 1, 0);
    chk("R4 period neg", offset_period, 3);
    chk("R4 polarity neg", offset_pos, 0);
  endtask

  task automatic t_comp_neg;
    cnt_c = 0; cnt_d = 0;
    ticks(9);
    step(0, 0, 0); step(0, 0, 0);
    chk("R10 chg strobes", cnt_c, 3);
    chk("R10 dis strobes", cnt_d, 0);
  endtask

  task automatic t_comp_disabled;
    write_en(0);
    chk("R9 enable cleared", comp_en, 0);
    cnt_c = 0; cnt_d = 0;
    ticks(9);
    step(0, 0, 0);
    chk("R11 no strobes when disabled", cnt_c + cnt_d, 0);
  endtask

  // pulses before quiet are ignored; also compensation halts during calibration
  task automatic t_quiet_wait;
    write_en(1);
    quiet = 0;
    start_cal(0);
    cnt_c = 0; cnt_d = 0;
    step(1, 0, 1); ticks(4); step(1, 0, 1); step(0, 1, 0); ticks(8);
    chk("R3 still requesting", cal_req, 1);
    chk("R3 period untouched", offset_period, 3);
    chk("R11 no strobes during calibration", cnt_c + cnt_d, 0);
    quiet = 1;
    step(0, 0, 0);
    step(1, 0, 0);
    ticks(2);
    step(1, 0, 0);
    chk("R3 period after quiet", offset_period, 2);
    chk("R3 polarity", offset_pos, 1);
    write_en(0);
  endtask

  task automatic t_opposite;
    start_cal(0);
    step(0, 0, 0);
    step(1, 0, 0);
    ticks(3);
    step(0, 1, 0);
    chk("R5 not finished after opposite", cal_stat, 1);
    ticks(4);
    step(0, 1, 0);
    ticks(2);
    step(0, 1, 0);
    chk("R5 period after restart", offset_period, 2);
    chk("R5 polarity after restart", offset_pos, 0);
  endtask

  task automatic t_both;
    start_cal(0);
    step(0, 0, 0);
    step(1, 0, 0);
    ticks(2);
    step(1, 1, 0);
    chk("R6 simultaneous ignored", cal_req, 1);
    ticks(1);
    step(1, 0, 0);
    chk("R6 period", offset_period, 3);
  endtask

  task automatic t_timeout_none;
    start_cal(1);
    step(0, 0, 0);
    ticks(64);
    chk("R7 not yet timed out", cal_req, 1);
    step(0, 0, 0);
    chk("R7 default period", offset_period, DEFP);
    chk("R7 default polarity", offset_pos, 1);
    chk("R8 stat after timeout", cal_stat, 0);
  endtask

  task automatic t_timeout_after_first;
    start_cal(0);
    step(0, 0, 0);
    step(0, 1, 0);
    ticks(63);
    step(0, 0, 0);
    chk("R7 waiting second", cal_stat, 1);
    ticks(1);
    step(0, 0, 0);
    chk("R7 default after first", offset_period, DEFP);
    chk("R7 default pol after first", offset_pos, 1);
    chk("R8 req after timeout", cal_req, 0);
  endtask

  task automatic t_zero_period;
    start_cal(0);
    step(0, 0, 0);
    step(0, 1, 1);
    step(0, 1, 0);
    chk("R4 zero period", offset_period, 0);
    write_en(1);
    cnt_c = 0; cnt_d = 0;
    ticks(10);
    step(0, 0, 0);
    chk("R11 no strobes at zero period", cnt_c + cnt_d, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; tick = 0; vfc_pos = 0; vfc_neg = 0; quiet = 0;
    cal_req_set = 0; cal_cmd = 0; en_wr = 0; en_wdata = 0;
    cnt_c = 0; cnt_d = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_measure_pos();
    t_comp_pos();
    t_measure_neg_cmd();
    t_comp_neg();
    t_comp_disabled();
    t_quiet_wait();
    t_opposite();
    t_both();
    t_timeout_none();
    t_timeout_after_first();
    t_zero_period();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule